// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the integer register file of a processor that keeps procedure contexts on chip. Its 138 registers of 32 bits each are split into 10 globals that every procedure sees and eight circular windows of 16 physical registers. Only one window is visible at a time; a current-window pointer picks it. Each window exposes 32 logical registers through a 5-bit register number. The six low registers of one window are the same physical storage as the six high registers of the next window. A caller therefore places arguments in its outgoing registers, and the callee finds them in its incoming registers. Calls and returns only move the pointer and copy no data.

The pipeline reads two registers and writes one per cycle. Call and return strobes move the pointer. A counter tracks how many windows hold live frames. A call with seven windows resident raises an overflow trap. A return with one window resident raises an underflow trap. In both cases the pointer move waits until an external handler has spilled or filled a window and acknowledges it. The spill and fill transfers are done outside this block.

Top module: `regwin_file`

## Requirements
- R1: After a synchronous active-low reset the window pointer is 0, the resident count is 1, both traps are low and every register reads zero.
- R2: Logical register 0 always reads as zero on both read ports, and writes to it have no effect.
- R3: Logical registers 1 to 9 are globals: the same physical registers in every window.
- R4: An accepted call raises the pointer by 1 and the resident count by 1. An accepted return lowers both by 1. The pointer wraps modulo 8 (7 goes to 0 on a call), and it never changes by more than one step per cycle.
- R5: Logical registers 26 to 31 of the window at pointer p are the physical registers that logical registers 10 to 15 address at pointer p-1 (mod 8). Data written by a caller to 10+k is read by the callee at 26+k, and data written by the callee to 26+k is read at 10+k after the return. This also holds across the wrap from window 7 to window 0.
- R6: Logical registers 16 to 25 are private to each window. A caller's values in them survive a call and the matching return.
- R7: Writes take effect at the rising clock edge and reads are combinational. A read of the register being written in the same cycle returns the new data.
- R8: A call with 7 windows resident sets overflow_trap at that edge and leaves the pointer unchanged. On spill_ack the held call completes: the pointer advances, the resident count stays 7 and the trap clears.
- R9: A return with 1 window resident sets underflow_trap and leaves the pointer unchanged. On fill_ack the held return completes: the pointer decreases, the resident count stays 1 and the trap clears.
- R10: While a trap is pending, call and return strobes are ignored. A call and a return in the same cycle are both ignored. An acknowledge with no trap pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_idx | input | 5 | Logical register number, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 5 | Logical register number, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Logical register number for the write |
| wr_data | input | 32 | Write data |
| call_req | input | 1 | Procedure call strobe |
| ret_req | input | 1 | Procedure return strobe |
| spill_ack | input | 1 | A window was saved externally; complete the held call |
| fill_ack | input | 1 | A window was restored externally; complete the held return |
| cur_win | output | 3 | Current window pointer |
| resident | output | 4 | Number of windows holding live frames |
| overflow_trap | output | 1 | A call is held until spill_ack |
| underflow_trap | output | 1 | A return is held until fill_ack |

## Verification
The bench passes arguments through the overlap in both directions. A design that used the next window instead of the previous one for the high group, or that was off by one in the group offset, would read zero or a neighbour's value there. Locals and globals are checked across a call and return, which catches a translation that aliases private registers. The bench drives the nesting depth to the overflow point twice, the second time across the pointer wrap from 7 to 0. It then unwinds to the underflow point. A design with the wrong threshold would trap one level early or late. A design that let strobes through during a pending trap would move the pointer twice. A design without the same-cycle bypass would return stale data on a read that collides with a write.

// File: rtl/rw_pkg.sv
// Package: shared constants and types of the register window file.
// Assumes the window count is a power of two so the pointer wraps naturally.
package rw_pkg;
    localparam int RW_DATA_W = 32;
    localparam int RW_NWIN   = 8;
    localparam int RW_NGLOB  = 10;
    localparam int RW_NSHARE = 6;
    localparam int RW_NLOCAL = 10;

    // Group a logical register number falls in
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } rw_group_e;
endpackage

// File: rtl/rw_index_map.sv
// Module: translates a logical register number into a physical index
// through the current window pointer. The high (incoming) group maps onto
// the low (outgoing) group of the previous window.
// Assumes NGLOB + 2*NSHARE + NLOCAL equals 2**LIDX_W and NWIN is a power of two.
module rw_index_map
    import rw_pkg::*;
#(
    parameter int NWIN   = RW_NWIN,
    parameter int NGLOB  = RW_NGLOB,
    parameter int NSHARE = RW_NSHARE,
    parameter int NLOCAL = RW_NLOCAL,
    parameter int LIDX_W = 5,
    parameter int WP_W   = $clog2(NWIN),
    parameter int PIDX_W = $clog2(NGLOB + NWIN * (NSHARE + NLOCAL))
) (
    input  logic [LIDX_W-1:0] lidx,
    input  logic [WP_W-1:0]   cwp,
    output logic [PIDX_W-1:0] pidx
);
    localparam int BLK     = NSHARE + NLOCAL;
    localparam int OUT_END = NGLOB + NSHARE;
    localparam int LOC_END = OUT_END + NLOCAL;

    rw_group_e       grp;
    logic [WP_W-1:0] wsel;
    int              off;

    // Classify the logical number into its group
    always_comb begin
        if (int'(lidx) < NGLOB)        grp = GRP_GLOBAL;
        else if (int'(lidx) < OUT_END) grp = GRP_OUT;
        else if (int'(lidx) < LOC_END) grp = GRP_LOCAL;
        else                           grp = GRP_IN;
    end

    // Pick window block and offset within it, then form the physical index
    always_comb begin
        wsel = cwp;
        off  = 0;
        case (grp)
            GRP_GLOBAL: off = int'(lidx);
            GRP_OUT:    off = int'(lidx) - NGLOB;
            GRP_LOCAL:  off = NSHARE + int'(lidx) - OUT_END;
            default: begin
                wsel = cwp - 1'b1;
                off  = int'(lidx) - LOC_END;
            end
        endcase
        if (grp == GRP_GLOBAL) pidx = PIDX_W'(off);
        else                   pidx = PIDX_W'(NGLOB + int'(wsel) * BLK + off);
    end
endmodule

// File: rtl/rw_window_ctrl.sv
// Module: current-window pointer, resident-window count and trap state.
// A call at the resident limit or a return at depth one is held behind a
// trap until the external handler acknowledges it.
// Assumes NWIN is a power of two.
module rw_window_ctrl
    import rw_pkg::*;
#(
    parameter int NWIN  = RW_NWIN,
    parameter int WP_W  = $clog2(NWIN),
    parameter int DEP_W = $clog2(NWIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             call_req,
    input  logic             ret_req,
    input  logic             spill_ack,
    input  logic             fill_ack,
    output logic [WP_W-1:0]  cwp,
    output logic [DEP_W-1:0] occ,
    output logic             ovf,
    output logic             unf
);
    localparam logic [DEP_W-1:0] OCC_MAX = DEP_W'(NWIN - 1);
    localparam logic [DEP_W-1:0] OCC_MIN = DEP_W'(1);

    // Advance or retreat the pointer, or hold it behind a trap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp <= '0;
            occ <= OCC_MIN;
            ovf <= 1'b0;
            unf <= 1'b0;
        end else if (ovf) begin
            if (spill_ack) begin
                cwp <= cwp + 1'b1;
                ovf <= 1'b0;
            end
        end else if (unf) begin
            if (fill_ack) begin
                cwp <= cwp - 1'b1;
                unf <= 1'b0;
            end
        end else if (call_req && !ret_req) begin
            if (occ == OCC_MAX) ovf <= 1'b1;
            else begin
                cwp <= cwp + 1'b1;
                occ <= occ + 1'b1;
            end
        end else if (ret_req && !call_req) begin
            if (occ == OCC_MIN) unf <= 1'b1;
            else begin
                cwp <= cwp - 1'b1;
                occ <= occ - 1'b1;
            end
        end
    end

    // R4
    cwp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cwp != $past(cwp)) |-> (cwp == $past(cwp) + 1'b1 || cwp == $past(cwp) - 1'b1));

    // R4
    occ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ >= OCC_MIN && occ <= OCC_MAX));

    // R8
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> ($past(call_req) && $past(occ) == OCC_MAX && $stable(cwp)));

    // R9
    unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unf) |-> ($past(ret_req) && $past(occ) == OCC_MIN && $stable(cwp)));

    // R10
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf && !spill_ack) || (unf && !fill_ack)) |=> ($stable(cwp) && $stable(occ)));

    // R10
    trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));
endmodule

// File: rtl/rw_storage.sv
// Module: flop array of physical registers with one write port and NRD
// combinational read ports. Physical index 0 is hard zero; a read that hits
// the index being written returns the incoming data.
// Assumes the indices it receives are below PHYS_N.
module rw_storage
    import rw_pkg::*;
#(
    parameter int DATA_W = RW_DATA_W,
    parameter int PHYS_N = 138,
    parameter int NRD    = 2,
    parameter int PIDX_W = $clog2(PHYS_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PIDX_W-1:0] wpidx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PIDX_W-1:0] rpidx [NRD],
    output logic [DATA_W-1:0] rdata [NRD]
);
    logic [DATA_W-1:0] mem [PHYS_N];
    logic              we_eff;

    // Writes to the zero register are dropped
    always_comb we_eff = we && (wpidx != '0);

    // Clear on reset, otherwise store the write data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS_N; i++) mem[i] <= '0;
        end else if (we_eff) begin
            mem[wpidx] <= wdata;
        end
    end

    generate
        for (genvar p = 0; p < NRD; p++) begin : g_rd
            // Read with zero override and same-cycle write bypass
            always_comb begin
                if (rpidx[p] == '0)                  rdata[p] = '0;
                else if (we_eff && wpidx == rpidx[p]) rdata[p] = wdata;
                else                                  rdata[p] = mem[rpidx[p]];
            end
        end
    endgenerate
endmodule

// File: rtl/regwin_file.sv
// Module: top of the overlapping register window file. Three index
// translators (two reads, one write) share the current window pointer.
// Assumes spill/fill transfers are done by an external handler.
module regwin_file
    import rw_pkg::*;
#(
    parameter int DATA_W = RW_DATA_W,
    parameter int NWIN   = RW_NWIN,
    parameter int NGLOB  = RW_NGLOB,
    parameter int NSHARE = RW_NSHARE,
    parameter int NLOCAL = RW_NLOCAL,
    parameter int LIDX_W = 5,
    parameter int WP_W   = $clog2(NWIN),
    parameter int DEP_W  = $clog2(NWIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LIDX_W-1:0] rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [LIDX_W-1:0] rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [LIDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic              spill_ack,
    input  logic              fill_ack,
    output logic [WP_W-1:0]   cur_win,
    output logic [DEP_W-1:0]  resident,
    output logic              overflow_trap,
    output logic              underflow_trap
);
    localparam int PHYS_N = NGLOB + NWIN * (NSHARE + NLOCAL);
    localparam int PIDX_W = $clog2(PHYS_N);
    localparam int NRD    = 2;
    localparam int NPORT  = NRD + 1;

    logic [LIDX_W-1:0] lidx  [NPORT];
    logic [PIDX_W-1:0] pidx  [NPORT];
    logic [PIDX_W-1:0] rpidx [NRD];
    logic [DATA_W-1:0] rdata [NRD];
    logic [WP_W-1:0]   cwp;

    // Gather the logical numbers of all ports; write port is last
    always_comb begin
        lidx[0]  = rd_a_idx;
        lidx[1]  = rd_b_idx;
        lidx[2]  = wr_idx;
        rpidx[0] = pidx[0];
        rpidx[1] = pidx[1];
    end

    rw_window_ctrl #(.NWIN(NWIN), .WP_W(WP_W), .DEP_W(DEP_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .call_req(call_req), .ret_req(ret_req),
        .spill_ack(spill_ack), .fill_ack(fill_ack),
        .cwp(cwp), .occ(resident),
        .ovf(overflow_trap), .unf(underflow_trap)
    );

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_map
            rw_index_map #(
                .NWIN(NWIN), .NGLOB(NGLOB), .NSHARE(NSHARE), .NLOCAL(NLOCAL),
                .LIDX_W(LIDX_W), .WP_W(WP_W), .PIDX_W(PIDX_W)
            ) u_map (
                .lidx(lidx[p]), .cwp(cwp), .pidx(pidx[p])
            );
        end
    endgenerate

    rw_storage #(.DATA_W(DATA_W), .PHYS_N(PHYS_N), .NRD(NRD), .PIDX_W(PIDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en), .wpidx(pidx[2]), .wdata(wr_data),
        .rpidx(rpidx), .rdata(rdata)
    );

    // Drive the outputs
    always_comb begin
        rd_a_data = rdata[0];
        rd_b_data = rdata[1];
        cur_win   = cwp;
    end
endmodule

// File: tb/regwin_file_bench.sv
module regwin_file_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, call_req = 1'b0, ret_req = 1'b0;
    logic        spill_ack = 1'b0, fill_ack = 1'b0;
    logic [2:0]  cur_win;
    logic [3:0]  resident;
    logic        overflow_trap, underflow_trap;

    int n_chk = 0;
    int n_bad = 0;

    regwin_file u_regwin_file (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .call_req(call_req), .ret_req(ret_req),
        .spill_ack(spill_ack), .fill_ack(fill_ack),
        .cur_win(cur_win), .resident(resident),
        .overflow_trap(overflow_trap), .underflow_trap(underflow_trap)
    );

    always #2 clk = ~clk;

    // Ops: 0 write, 1 read-check, 2 call, 3 return; {op, idx, data}
    localparam int NVEC = 13;
    localparam logic [38:0] VEC [NVEC] = '{
        {2'd0, 5'd1,  32'h1111_1111},
        {2'd0, 5'd16, 32'h0000_00A0},
        {2'd0, 5'd10, 32'h0000_00B0},
        {2'd2, 5'd0,  32'h0},
        {2'd1, 5'd26, 32'h0000_00B0},   // R5 argument visible to callee
        {2'd1, 5'd16, 32'h0},           // R6 callee local is its own
        {2'd1, 5'd1,  32'h1111_1111},   // R3 global in callee
        {2'd0, 5'd16, 32'h0000_00C1},
        {2'd0, 5'd26, 32'h0000_00D1},
        {2'd3, 5'd0,  32'h0},
        {2'd1, 5'd10, 32'h0000_00D1},   // R5 result visible to caller
        {2'd1, 5'd16, 32'h0000_00A0},   // R6 caller local preserved
        {2'd1, 5'd1,  32'h1111_1111}    // R3 global after return
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] idx, input logic [31:0] exp, input string req);
        @(negedge clk);
        rd_a_idx = idx; rd_b_idx = idx;
        #1;
        chk(req, rd_a_data, exp);
        chk(req, rd_b_data, exp);
    endtask

    // Pulse strobes for one edge; results sampled 1 ns after the next negedge
    task automatic strobe(input logic c, input logic r, input logic s, input logic f);
        @(negedge clk);
        call_req = c; ret_req = r; spill_ack = s; fill_ack = f;
        @(negedge clk);
        call_req = 1'b0; ret_req = 1'b0; spill_ack = 1'b0; fill_ack = 1'b0;
        #1;
    endtask

    task automatic state(input string req, input int w, input int d, input logic o, input logic u);
        chk(req, 32'(cur_win), 32'(w));
        chk(req, 32'(resident), 32'(d));
        chk(req, 32'(overflow_trap), 32'(o));
        chk(req, 32'(underflow_trap), 32'(u));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        state("R1", 0, 1, 1'b0, 1'b0);
        rd(5'd5, 32'h0, "R1");
        rd(5'd20, 32'h0, "R1");

        // Table walk: argument and result passing, locals, globals
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][38:37])
                2'd0: wr(VEC[i][36:32], VEC[i][31:0]);
                2'd1: rd(VEC[i][36:32], VEC[i][31:0], "R3/R5/R6 table");
                2'd2: strobe(1'b1, 1'b0, 1'b0, 1'b0);
                default: strobe(1'b0, 1'b1, 1'b0, 1'b0);
            endcase
        end
        state("R4 back at window 0", 0, 1, 1'b0, 1'b0);

        // R2 zero register
        wr(5'd0, 32'hDEAD_BEEF);
        rd(5'd0, 32'h0, "R2");

        // R7 same-cycle bypass, then the stored value
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd7; wr_data = 32'h0BAD_CAFE; rd_a_idx = 5'd7;
        #1;
        chk("R7 bypass", rd_a_data, 32'h0BAD_CAFE);
        @(negedge clk);
        wr_en = 1'b0;
        rd(5'd7, 32'h0BAD_CAFE, "R7 stored");

        // Deep nesting towards overflow
        wr(5'd16, 32'h0000_00E0);
        for (int i = 0; i < 6; i++) strobe(1'b1, 1'b0, 1'b0, 1'b0);
        state("R4 depth", 6, 7, 1'b0, 1'b0);
        wr(5'd10, 32'h0000_0066);
        strobe(1'b1, 1'b0, 1'b0, 1'b0);
        state("R8 trap raised", 6, 7, 1'b1, 1'b0);
        strobe(1'b1, 1'b0, 1'b0, 1'b0);
        state("R10 call ignored in trap", 6, 7, 1'b1, 1'b0);
        strobe(1'b0, 1'b0, 1'b1, 1'b0);
        state("R8 spill completes", 7, 7, 1'b0, 1'b0);
        rd(5'd26, 32'h0000_0066, "R5 after spill");
        wr(5'd10, 32'h0000_0077);
        strobe(1'b1, 1'b0, 1'b0, 1'b0);
        state("R8 trap again", 7, 7, 1'b1, 1'b0);
        strobe(1'b0, 1'b0, 1'b1, 1'b0);
        state("R4 wrap to 0", 0, 7, 1'b0, 1'b0);
        rd(5'd26, 32'h0000_0077, "R5 wrap overlap");
        rd(5'd16, 32'h0000_00E0, "R6 local of window 0");

        // R10 simultaneous call and return
        strobe(1'b1, 1'b1, 1'b0, 1'b0);
        state("R10 call+ret ignored", 0, 7, 1'b0, 1'b0);

        // Unwind towards underflow
        for (int i = 0; i < 6; i++) strobe(1'b0, 1'b1, 1'b0, 1'b0);
        state("R4 unwound", 2, 1, 1'b0, 1'b0);
        strobe(1'b0, 1'b1, 1'b0, 1'b0);
        state("R9 trap raised", 2, 1, 1'b0, 1'b1);
        strobe(1'b0, 1'b1, 1'b0, 1'b0);
        state("R10 return ignored in trap", 2, 1, 1'b0, 1'b1);
        strobe(1'b0, 1'b0, 1'b0, 1'b1);
        state("R9 fill completes", 1, 1, 1'b0, 1'b0);
        strobe(1'b0, 1'b0, 1'b1, 1'b1);
        state("R10 stray ack ignored", 1, 1, 1'b0, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule